// File: doc/BRIEF.md
# Configuration Phase Sequencer

This block steps a programmable logic device through bring-up. Once the supply-ready indication arrives, it first wipes the configuration storage. It then waits for the external loader to finish writing the configuration data. Last, it releases the global control nets in a fixed, staggered order. A qualified reconfiguration request restarts the whole sequence at any point.

The shared status pin is open-drain. The block pulls it low with `init_drive_low` for as long as the wipe runs. The pin's resolved level comes back in on `init_in`. Another party on the board can keep the pin low after the wipe has finished. The sequencer then does not move to the load phase until it reads the pin high.

The wipe length and the minimum accepted request width are cycle counts set by parameters. At a 100 MHz configuration clock, the default request width of 30 cycles equals 300 ns.

Top module: `cfg_phase_seq`

## Requirements
- R1: While `rst_n` is low, `init_drive_low`, `gts_hold`, `gsr_hold` and `gwe_hold` are 1 and `done` is 0.
- R2: At the clock edge that samples `por_done` high, the wipe phase begins. `init_drive_low` then stays 1 for exactly CLEAR_CYCLES clock cycles.
- R3: Until `por_done` is sampled high after reset, the block stays idle. It keeps `init_drive_low` at 1 and `done` at 0, and the wipe count does not start.
- R4: After the wipe, `init_drive_low` is 0. The load phase is entered only at an edge where `init_in` is sampled 1. While `init_in` reads 0, the block waits with `done` at 0.
- R5: A `load_done` pulse sampled during the load phase sets `done` to 1 at that edge. `done` stays 1 until a restart.
- R6: `gts_hold` falls one clock after `done` rises.
- R7: `gsr_hold` and `gwe_hold` fall together, one clock after `gts_hold` falls.
- R8: A `prog_req` level that is sampled high on fewer than PROG_MIN consecutive edges has no effect.
- R9: When `prog_req` has been sampled high on PROG_MIN consecutive edges, the next edge restarts the wipe. This drops `done` and reasserts the three holds. The wipe keeps restarting for as long as `prog_req` stays high, and then runs its full length.
- R10: `load_done` has no effect outside the load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_done | input | 1 | Supply-ready indication; 1 lets the sequence start |
| prog_req | input | 1 | Reconfiguration request, active high, width-qualified |
| init_in | input | 1 | Sampled level of the open-drain status pin |
| load_done | input | 1 | Strobe from the loader: all configuration data written |
| init_drive_low | output | 1 | 1 pulls the open-drain status pin low |
| done | output | 1 | 1 once the full sequence has completed |
| gts_hold | output | 1 | 1 keeps device outputs in high impedance |
| gsr_hold | output | 1 | 1 keeps user flip-flops in their reset state |
| gwe_hold | output | 1 | 1 blocks writes to user storage elements |

## Verification
A qualified restart can land in the same cycle as a normal phase advance. Examples are a `load_done` strobe or a point in the staggered release. The restart must win.

The bench provokes this in two ways. It holds `load_done` high for the whole length of a long request. It also ends a request at exactly PROG_MIN cycles after the device is running.

A behavioural model, which keeps the phase as an integer, predicts every output on every cycle. Any cycle in which the advance won instead of the restart shows up as a mismatch on `done`, `init_drive_low` or a hold output.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        PH_POR       = 3'd0,
        PH_CLEAR     = 3'd1,
        PH_INIT_WAIT = 3'd2,
        PH_LOAD      = 3'd3,
        PH_DONE      = 3'd4,
        PH_GTS_OFF   = 3'd5,
        PH_RUN       = 3'd6
    } phase_e;

endpackage

// File: rtl/cfg_prog_qual.sv
module cfg_prog_qual #(
    parameter int PROG_MIN = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    output logic prog_qual
);
    localparam int PW = $clog2(PROG_MIN + 1);
    localparam logic [PW-1:0] P_SAT = PW'(PROG_MIN);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (!prog_req) begin
            qual_d.cnt = '0;
        end else if (qual_q.cnt != P_SAT) begin
            qual_d.cnt = qual_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '0;
        end else begin
            qual_q <= qual_d;
        end
    end

    assign prog_qual = (qual_q.cnt == P_SAT);

    AST_QUAL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        prog_qual |-> $past(prog_req)); // R8

endmodule

// File: rtl/cfg_seq_core.sv
module cfg_seq_core
    import cfg_seq_pkg::*;
#(
    parameter int CLEAR_CYCLES = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   por_done,
    input  logic   prog_qual,
    input  logic   init_in,
    input  logic   load_done,
    output phase_e phase_o
);
    localparam int CW = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYCLES - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] clr;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (prog_qual) begin
            core_d.ph  = PH_CLEAR;
            core_d.clr = '0;
        end else begin
            unique case (core_q.ph)
                PH_POR: begin
                    if (por_done) begin
                        core_d.ph  = PH_CLEAR;
                        core_d.clr = '0;
                    end
                end
                PH_CLEAR: begin
                    if (core_q.clr == CLR_LAST) begin
                        core_d.ph  = PH_INIT_WAIT;
                        core_d.clr = '0;
                    end else begin
                        core_d.clr = core_q.clr + 1'b1;
                    end
                end
                PH_INIT_WAIT: if (init_in)   core_d.ph = PH_LOAD;
                PH_LOAD:      if (load_done) core_d.ph = PH_DONE;
                PH_DONE:      core_d.ph = PH_GTS_OFF;
                PH_GTS_OFF:   core_d.ph = PH_RUN;
                PH_RUN:       core_d.ph = PH_RUN;
                default:      core_d.ph = PH_POR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.ph  <= PH_POR;
            core_q.clr <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign phase_o = core_q.ph;

    AST_CLEAR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_CLEAR) |-> (core_q.clr <= CLR_LAST)); // R2

    AST_LOAD_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_LOAD && $past(core_q.ph) == PH_INIT_WAIT) |-> $past(init_in)); // R4

    AST_DONE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ph == PH_DONE) |-> $past(load_done)); // R5

endmodule

// File: rtl/cfg_release_decode.sv
module cfg_release_decode
    import cfg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    output logic   init_drive_low,
    output logic   done,
    output logic   gts_hold,
    output logic   gsr_hold,
    output logic   gwe_hold
);
    always_comb begin
        init_drive_low = (phase_i == PH_POR) || (phase_i == PH_CLEAR);
        done           = (phase_i == PH_DONE) || (phase_i == PH_GTS_OFF) || (phase_i == PH_RUN);
        gts_hold       = (phase_i != PH_GTS_OFF) && (phase_i != PH_RUN);
        gsr_hold       = (phase_i != PH_RUN);
        gwe_hold       = (phase_i != PH_RUN);
    end

    AST_GTS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gts_hold) |-> ($past(done) && done)); // R6

    AST_GSR_AFTER_GTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gsr_hold) |-> ($past(gts_hold) == 1'b0)); // R7

    AST_DONE_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !init_drive_low); // R5

endmodule

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLEAR_CYCLES = 16,
    parameter int PROG_MIN     = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_done,
    input  logic prog_req,
    input  logic init_in,
    input  logic load_done,
    output logic init_drive_low,
    output logic done,
    output logic gts_hold,
    output logic gsr_hold,
    output logic gwe_hold
);
    logic   prog_qual;
    phase_e phase;

    cfg_prog_qual #(.PROG_MIN(PROG_MIN)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_req  (prog_req),
        .prog_qual (prog_qual)
    );

    cfg_seq_core #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_done  (por_done),
        .prog_qual (prog_qual),
        .init_in   (init_in),
        .load_done (load_done),
        .phase_o   (phase)
    );

    cfg_release_decode u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .phase_i        (phase),
        .init_drive_low (init_drive_low),
        .done           (done),
        .gts_hold       (gts_hold),
        .gsr_hold       (gsr_hold),
        .gwe_hold       (gwe_hold)
    );

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_qual |=> (init_drive_low && !done && gts_hold && gsr_hold && gwe_hold)); // R9

endmodule

// File: tb/cfg_phase_seq_bench.sv
module cfg_phase_seq_bench;
    localparam int CLEAR_CYCLES = 16;
    localparam int PROG_MIN     = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_done = 1'b0;
    logic prog_req = 1'b0;
    logic load_done = 1'b0;
    logic ext_hold = 1'b0;
    logic init_in;
    logic init_drive_low, done, gts_hold, gsr_hold, gwe_hold;

    int total = 0;
    int bad = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // open-drain pin: low if the block or the outside party pulls it
    assign init_in = ~init_drive_low & ~ext_hold;

    cfg_phase_seq #(.CLEAR_CYCLES(CLEAR_CYCLES), .PROG_MIN(PROG_MIN)) u_cfg_phase_seq (
        .clk(clk), .rst_n(rst_n), .por_done(por_done), .prog_req(prog_req),
        .init_in(init_in), .load_done(load_done), .init_drive_low(init_drive_low),
        .done(done), .gts_hold(gts_hold), .gsr_hold(gsr_hold), .gwe_hold(gwe_hold)
    );

    // behavioural reference: phase 0 idle, 1 wipe, 2 pin wait, 3 load,
    // 4 done, 5 outputs enabled, 6 running
    int m_phase = 0;
    int m_clr = 0;
    int m_pcnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_clr = 0; m_pcnt = 0;
        end else begin
            bit restart;
            restart = (m_pcnt >= PROG_MIN);
            m_pcnt = prog_req ? ((m_pcnt < PROG_MIN) ? m_pcnt + 1 : m_pcnt) : 0;
            if (restart) begin
                m_phase = 1; m_clr = 0;
            end else begin
                case (m_phase)
                    0: if (por_done) begin m_phase = 1; m_clr = 0; end
                    1: begin
                        m_clr++;
                        if (m_clr == CLEAR_CYCLES) m_phase = 2;
                    end
                    2: if (init_in) m_phase = 3;
                    3: if (load_done) m_phase = 4;
                    4: m_phase = 5;
                    5: m_phase = 6;
                    default: m_phase = 6;
                endcase
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R3";
            1: return "R2";
            2: return "R4";
            3: return "R10";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            string t;
            t = tag_of(m_phase);
            chk(t, "model init_drive_low", int'(init_drive_low), int'(m_phase <= 1));
            chk(t, "model done", int'(done), int'(m_phase >= 4));
            chk(t, "model gts_hold", int'(gts_hold), int'(m_phase < 5));
            chk(t, "model gsr_hold", int'(gsr_hold), int'(m_phase < 6));
            chk(t, "model gwe_hold", int'(gwe_hold), int'(m_phase < 6));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int n;
        step(3);
        @(negedge clk);
        chk("R1", "reset init_drive_low", int'(init_drive_low), 1);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset gts_hold", int'(gts_hold), 1);
        chk("R1", "reset gsr_hold", int'(gsr_hold), 1);
        chk("R1", "reset gwe_hold", int'(gwe_hold), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cmp_en = 1'b1;

        step(6);
        @(negedge clk);
        chk("R3", "idle init_drive_low", int'(init_drive_low), 1);
        chk("R3", "idle done", int'(done), 0);
        @(posedge clk); #1;

        // wipe length: one idle negedge before the sampling edge, then CLEAR_CYCLES
        por_done = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (init_drive_low) n++;
            else break;
        end
        chk("R2", "wipe length", n, CLEAR_CYCLES + 1);
        @(posedge clk); #1;

        step(2);
        load_done = 1'b1;
        step(1);
        load_done = 1'b0;
        @(negedge clk);
        chk("R5", "done after load", int'(done), 1);
        chk("R5", "gts still held", int'(gts_hold), 1);
        @(negedge clk);
        chk("R6", "gts released", int'(gts_hold), 0);
        chk("R6", "gsr still held", int'(gsr_hold), 1);
        @(negedge clk);
        chk("R7", "gsr released", int'(gsr_hold), 0);
        chk("R7", "gwe released", int'(gwe_hold), 0);
        @(posedge clk); #1;

        // request one cycle too short
        prog_req = 1'b1;
        step(PROG_MIN - 1);
        prog_req = 1'b0;
        step(3);
        @(negedge clk);
        chk("R8", "short request done", int'(done), 1);
        chk("R8", "short request gsr_hold", int'(gsr_hold), 0);
        @(posedge clk); #1;

        // long request, load strobe held alongside, pin kept low outside
        ext_hold = 1'b1;
        prog_req = 1'b1;
        load_done = 1'b1;
        step(PROG_MIN + 4);
        @(negedge clk);
        chk("R9", "held request done", int'(done), 0);
        chk("R9", "held request init_drive_low", int'(init_drive_low), 1);
        chk("R9", "held request gts_hold", int'(gts_hold), 1);
        chk("R9", "held request gwe_hold", int'(gwe_hold), 1);
        @(posedge clk); #1;
        prog_req = 1'b0;
        load_done = 1'b0;
        step(CLEAR_CYCLES + 6);
        @(negedge clk);
        chk("R4", "waiting pin released", int'(init_drive_low), 0);
        chk("R4", "waiting done", int'(done), 0);
        @(posedge clk); #1;
        load_done = 1'b1;
        step(1);
        load_done = 1'b0;
        step(2);
        @(negedge clk);
        chk("R10", "strobe outside load", int'(done), 0);
        @(posedge clk); #1;
        ext_hold = 1'b0;
        step(3);
        load_done = 1'b1;
        step(1);
        load_done = 1'b0;
        step(3);
        @(negedge clk);
        chk("R5", "second completion done", int'(done), 1);
        chk("R7", "second completion gsr_hold", int'(gsr_hold), 0);
        @(posedge clk); #1;

        // request exactly PROG_MIN cycles long is accepted
        prog_req = 1'b1;
        step(PROG_MIN);
        prog_req = 1'b0;
        step(1);
        @(negedge clk);
        chk("R9", "exact-width request done", int'(done), 0);
        chk("R9", "exact-width request init_drive_low", int'(init_drive_low), 1);
        @(posedge clk); #1;
        step(CLEAR_CYCLES + 4);
        load_done = 1'b1;
        step(1);
        load_done = 1'b0;
        step(4);
        @(negedge clk);
        chk("R7", "third completion gwe_hold", int'(gwe_hold), 0);

        finished = 1'b1;
        cmp_en = 1'b0;
        summary();
    end

endmodule